// File: doc/BRIEF.md
# Two-wire serial memory read slave

This block is the slave side of a two-wire serial memory holding 256 bytes of 8 bits. It oversamples the clock and data lines in the system clock domain and finds START and STOP conditions. It accepts transfers only for its 7-bit device address and drives the data line through an open-drain enable. Any byte can be read out. The master first sends a device byte with the direction bit at 0, followed by one word-address byte. After a repeated START it sends the device byte again with the direction bit at 1. A read may also start directly at the current position, and any read can stream on for as long as the master keeps acknowledging.

One address pointer serves every access. Loading a word address sets it. Each byte sent out advances it by one, and it wraps from 255 to 0. The pointer keeps its value between transfers, so a read with no address phase continues one past the last byte accessed. Data bytes that a master tries to write after the word address are refused. The array contents are fixed by a computed pattern that is loaded at reset.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the pointer is 0 and `sda_oe_o` is 0 (line released). A read with no address phase then returns the byte at address 0.
- R2: A device byte whose upper 7 bits differ from `DEV_ADDR` is not acknowledged. `sda_oe_o` then stays 0 until the next START.
- R3: A device byte matching `DEV_ADDR` with direction bit 1 is acknowledged. The slave then sends the byte at the pointer and the pointer advances by one.
- R4: A device byte with direction bit 0 followed by a word address N is acknowledged at both bytes. After a repeated START and a read device byte, the slave returns the byte at N.
- R5: Each master acknowledge (line low on the ninth clock) after a data byte makes the slave send the byte at the next address. Address 255 is followed by address 0.
- R6: A master no-acknowledge followed by STOP releases the line. The next read with no address phase returns the byte one past the last one sent.
- R7: The slave changes `sda_oe_o` only while SCL is low. Data is sent most significant bit first.
- R8: A START or STOP seen in the middle of a byte abandons that transfer. A word address that is not complete does not change the pointer, and a new START begins a fresh device byte.
- R9: The byte stored at address i is ((i * 37) XOR 0x5A) mod 256 with the default parameters.
- R10: After a word address, any further data byte written by the master is not acknowledged and leaves the pointer at the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest cases to reach are conditions in the middle of a byte: a repeated START that cuts a device byte short, and a STOP inside a word address. Both have to leave the pointer untouched. The bench drives these with a partial-byte task that clocks only some bits before issuing the condition. It then checks through a plain current-position read that the pointer is unchanged. Wrap-around is reached with a random read at 254 that streams past the top of the array. Random sequences of current-position and random reads of random length, run from a fixed seed, keep a bench model of the pointer in step with the block.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } sm_state_e;
endpackage

// File: rtl/sm_sync.sv
module sm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter bit RST_V  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_V}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sm_bus_events.sv
module sm_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_s_i;
  assign scl_fall_o = scl_q && !scl_s_i;
  // conditions only count while clock stays high across both samples
  assign start_o    = scl_q && scl_s_i && sda_q && !sda_s_i;
  assign stop_o     = scl_q && scl_s_i && !sda_q && sda_s_i;
endmodule

// File: rtl/sm_mem.sv
module sm_mem #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int PAT_MUL = 37,
  parameter int PAT_XOR = 'h5A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= DW'((i * PAT_MUL) ^ PAT_XOR);
      else         mem_q[i] <= mem_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int              AW       = 8,
  parameter int              DW       = 8,
  parameter int              SYNC_N   = 2,
  parameter logic [DW-2:0]   DEV_ADDR = 7'h50,
  parameter int              PAT_MUL  = 37,
  parameter int              PAT_XOR  = 'h5A
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  import sm_pkg::*;

  localparam int BCW = $clog2(DW + 1);

  logic          scl_s, sda_s;
  logic          scl_rise, scl_fall, start_w, stop_w;
  logic [DW-1:0] rd_data;

  sm_state_e     state_q;
  logic [BCW-1:0] bit_cnt_q;
  logic [DW-1:0] rx_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          rw_q, mack_q, oe_q;

  sm_sync #(.W(2), .STAGES(SYNC_N), .RST_V(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  sm_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_w),
    .stop_o    (stop_w)
  );

  sm_mem #(.AW(AW), .DW(DW), .PAT_MUL(PAT_MUL), .PAT_XOR(PAT_XOR)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (ptr_q),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_w) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_w) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WORD: begin
          if (scl_rise && bit_cnt_q < BCW'(DW)) begin
            rx_q      <= {rx_q[DW-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (scl_fall && bit_cnt_q == BCW'(DW)) begin
            if (state_q == ST_DEV) begin
              if (rx_q[DW-1:1] == DEV_ADDR) begin
                oe_q    <= 1'b1;
                rw_q    <= rx_q[0];
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end else begin
              oe_q    <= 1'b1;
              ptr_q   <= rx_q[AW-1:0];
              state_q <= ST_WORD_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data;
              oe_q    <= ~rd_data[DW-1];
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WORD;
            end
          end
        end
        ST_WORD_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            state_q <= ST_SKIP;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == BCW'(DW - 1)) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              oe_q      <= ~tx_q[DW-2];
              tx_q      <= tx_q << 1;
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              bit_cnt_q <= '0;
              tx_q      <= rd_data;
              oe_q      <= ~rd_data[DW-1];
              ptr_q     <= ptr_q + 1'b1;
              state_q   <= ST_TX;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) && !$past(start_w || stop_w) |-> !scl_s); // R7

  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_SKIP) |-> !sda_oe_o); // R2

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q != $past(ptr_q)) && ($past(state_q) != ST_WORD) |-> ptr_q == AW'($past(ptr_q) + 1'b1)); // R5

  AST_BITCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= BCW'(DW)); // R8

  AST_TX_RELEASE_MACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MACK) |-> !sda_oe_o); // R6
endmodule

// File: tb/serial_mem_slave_bench.sv
module serial_mem_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic oe;
  wire  sda_line = sda_m & ~oe;

  int n_chk = 0, n_fail = 0, viol = 0, oe_seen = 0;
  bit watch = 1'b0, done = 1'b0, scl_prev = 1'b1, oe_prev = 1'b0;
  logic [7:0] mptr = 8'h00;

  serial_mem_slave u_serial_mem_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(oe));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && (oe != oe_prev)) viol++;
    if (watch && oe) oe_seen++;
    scl_prev = scl;
    oe_prev  = oe;
  end

  function automatic logic [7:0] exp_byte(input logic [7:0] a);
    return 8'((int'(a) * 37) ^ 'h5A);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); ack = ~sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      scl = 1'b1; wq(Q); d = {d[6:0], sda_line}; wq(Q); scl = 1'b0; wq(2 * Q);
    end
    sda_m = ~give_ack; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic read_stream(input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(d == exp_byte(mptr), req, d, exp_byte(mptr));
      mptr = mptr + 8'd1;
    end
    bus_stop();
  endtask

  task automatic cur_read(input int n, input string req);
    bit ack;
    bus_start();
    send_byte(8'hA1, ack);
    check(ack, "R3 device ack", ack, 1);
    read_stream(n, req);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    bit ack;
    bus_start();
    send_byte(8'hA0, ack);
    check(ack, "R4 write device ack", ack, 1);
    send_byte(a, ack);
    check(ack, "R4 word ack", ack, 1);
    mptr = a;
    bus_start();
    send_byte(8'hA1, ack);
    check(ack, "R4 read device ack", ack, 1);
    read_stream(n, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    void'($urandom(32'd4711));
    wq(5);
    check(oe == 1'b0, "R1 oe in reset", oe, 0);
    rst_n = 1'b1;
    wq(5);
    check(oe == 1'b0, "R1 oe after reset", oe, 0);
    cur_read(1, "R1 R9 first byte at 0");
    cur_read(3, "R3 R7 current read stream");
    rand_read(8'h80, 1, "R4 random read");
    cur_read(1, "R6 continue after nack");
    rand_read(8'hFE, 4, "R5 wrap stream");
    // R2 mismatched device address
    watch = 1'b1;
    bus_start();
    send_byte(8'hA3, ack);
    check(!ack, "R2 no ack on mismatch", ack, 0);
    send_byte(8'h00, ack);
    bus_stop();
    watch = 1'b0;
    check(oe_seen == 0, "R2 line never driven", oe_seen, 0);
    cur_read(1, "R2 pointer unaffected");
    // R8 repeated START inside device byte
    bus_start();
    send_bits(8'hA1, 4);
    bus_start();
    send_byte(8'hA1, ack);
    check(ack, "R8 ack after restart", ack, 1);
    read_stream(2, "R8 read after restart");
    // R8 STOP inside word address
    bus_start();
    send_byte(8'hA0, ack);
    send_bits(8'h10, 3);
    bus_stop();
    cur_read(1, "R8 partial word ignored");
    // R10 write data refused
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h40, ack);
    check(ack, "R10 word ack", ack, 1);
    send_byte(8'h99, ack);
    check(!ack, "R10 data not acked", ack, 0);
    bus_stop();
    mptr = 8'h40;
    cur_read(1, "R10 pointer kept");
    for (int it = 0; it < 25; it++) begin
      int n = 1 + int'($urandom % 5);
      if ($urandom % 2) rand_read(8'($urandom), n, "R4 R5 random op");
      else              cur_read(n, "R3 R5 random op");
    end
    check(viol == 0, "R7 oe stable while SCL high", viol, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule